// File: doc/BRIEF.md
# Comparator-Driven Rank Sorter with Symmetric Trimming

The block orders a set of analog elements by a measured parameter that it never sees directly. Each element is identified only by an index. To learn the order, the block selects two indices and asks an external comparator which one is larger. It waits as long as needed for the one-bit answer, then chooses the next pair. From these answers it builds a rank table in registers that maps every rank, counted from the smallest element upward, to the index of the element holding that rank.

A start pulse supplies the number of elements and a trim count. When ranking finishes, the block can discard a symmetric band of extremes: the lowest q ranks and the highest q ranks are flagged as dropped, and the entries between them keep their order. The trim count is a runtime value that is clipped to a parameter limit. The table and the keep flag are read through a rank-addressed read port after the done pulse.

Top module: `rank_sorter`

## Requirements
- R1: While reset is held and right after it, `done`, `busy` and `cmp_req` are all 0.
- R2: After `done`, reading ranks 0 to n-1 on `rd_rank` returns each entry index in 0..n-1 exactly once, ordered so that the comparator value is non-decreasing with rank (rank 0 is the smallest).
- R3: Entries with equal values (the comparator answers 0 in both directions) are ranked so that the lower index takes the lower rank.
- R4: Only one comparison is outstanding at a time: `cmp_req` stays high with `cmp_idx_a` and `cmp_idx_b` unchanged until the cycle in which `cmp_ack` is high. The two indices differ and both lie below n. Any number of cycles may pass before the acknowledge, including zero.
- R5: A run over n entries issues no more than n*(n-1)/2 comparisons.
- R6: `done` is high for exactly one cycle per run. A run with n of 0 or 1 issues no comparison and still signals `done`.
- R7: After `done`, `rd_keep` is 1 at rank r exactly when q <= r < n-q, where q is the effective trim count. Ranks at or beyond n read `rd_keep` = 0.
- R8: The effective trim count q is `trim_count` clipped to the parameter MAX_TRIM.
- R9: A `start` pulse while `busy` is 1 is ignored: the running job finishes with its own entry count and trim count.
- R10: An entry count above the parameter MAX_N is clipped to MAX_N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads the counts and begins a run |
| num_entries | input | CNT_W | Number of entries to rank |
| trim_count | input | CNT_W | Entries to drop at each end of the order |
| cmp_req | output | 1 | A comparison is being requested |
| cmp_idx_a | output | IDX_W | First entry of the pair |
| cmp_idx_b | output | IDX_W | Second entry of the pair |
| cmp_ack | input | 1 | Comparator answer is valid this cycle |
| cmp_a_gt_b | input | 1 | 1 when entry a is strictly larger than entry b |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when ranking and trimming are complete |
| rd_rank | input | IDX_W | Rank to read, 0 is the smallest |
| rd_index | output | IDX_W | Entry index that holds `rd_rank` |
| rd_keep | output | 1 | 1 when `rd_rank` survives trimming |

## Verification
The assertions take for granted that the comparator raises `cmp_ack` only while `cmp_req` is high, for one cycle per request, and that its answers are consistent with one fixed set of values over a run. The bench comparator reads stored integer values, clears its acknowledge on every cycle and raises it only against a live request after a random delay of zero to three cycles, so these conditions always hold. Value sets include random values with many ties, sorted, reverse-sorted and all-equal sets, so the equal-value ordering and the worst-case comparison count are both reached.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rs_rank_table.sv
module rs_rank_table #(
  parameter int MAX_N = 16,
  localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_en,
  input  logic             shift_en,
  input  logic [IDX_W-1:0] shift_dst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [IDX_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_a_slot,
  output logic [IDX_W-1:0] rd_a_val,
  input  logic [IDX_W-1:0] rd_u_slot,
  output logic [IDX_W-1:0] rd_u_val
);
  logic [IDX_W-1:0] tbl     [MAX_N];
  logic [IDX_W-1:0] tbl_nxt [MAX_N];
  logic [MAX_N-1:0] slot_en;

  for (genvar r = 0; r < MAX_N; r++) begin : g_slot
    if (r == 0) begin : g_bottom
      always_comb begin
        tbl_nxt[r] = tbl[r];
        if (init_en)
          tbl_nxt[r] = IDX_W'(r);
        else if (wr_en && wr_slot == IDX_W'(r))
          tbl_nxt[r] = wr_val;
      end
    end else begin : g_upper
      always_comb begin
        tbl_nxt[r] = tbl[r];
        if (init_en)
          tbl_nxt[r] = IDX_W'(r);
        else if (shift_en && shift_dst == IDX_W'(r))
          tbl_nxt[r] = tbl[r-1];
        else if (wr_en && wr_slot == IDX_W'(r))
          tbl_nxt[r] = wr_val;
      end
    end

    assign slot_en[r] = init_en || shift_en || wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbl[r] <= IDX_W'(r);
      else if (slot_en[r])
        tbl[r] <= tbl_nxt[r];
    end
  end

  assign rd_a_val = tbl[rd_a_slot];
  assign rd_u_val = tbl[rd_u_slot];

  // A shift and a write in the same cycle must target different slots (R2)
  assert_no_slot_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && wr_en) |-> (shift_dst != wr_slot));
endmodule

// File: rtl/rs_seq.sv
module rs_seq
  import rs_pkg::*;
#(
  parameter int MAX_N = 16,
  localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int CNT_W = $clog2(MAX_N + 1),
  localparam int PW    = 2 * CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] num_entries,
  input  logic             cmp_ack,
  input  logic             cmp_a_gt_b,
  output logic             cmp_req,
  output logic [IDX_W-1:0] cmp_b,
  output logic [IDX_W-1:0] probe_slot,
  output logic             init_en,
  output logic             shift_en,
  output logic [IDX_W-1:0] shift_dst,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_slot,
  output logic [IDX_W-1:0] wr_val,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] n_eff
);
  seq_state_t       st, st_nxt;
  logic [IDX_W-1:0] cur, cur_nxt;
  logic [IDX_W-1:0] pos, pos_nxt;
  logic [CNT_W-1:0] n_q, n_nxt;
  logic             n_ld;
  logic             ptr_en;
  logic             last_entry;
  logic [CNT_W-1:0] n_clip;

  assign n_clip     = (num_entries > CNT_W'(MAX_N)) ? CNT_W'(MAX_N) : num_entries;
  assign last_entry = (CNT_W'(cur) + CNT_W'(1)) == n_q;

  always_comb begin
    st_nxt   = st;
    cur_nxt  = cur;
    pos_nxt  = pos;
    n_nxt    = n_q;
    n_ld     = 1'b0;
    init_en  = 1'b0;
    shift_en = 1'b0;
    wr_en    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          n_ld    = 1'b1;
          n_nxt   = n_clip;
          init_en = 1'b1;
          cur_nxt = IDX_W'(1);
          pos_nxt = IDX_W'(1);
          st_nxt  = (n_clip <= CNT_W'(1)) ? ST_FIN : ST_CMP;
        end
      end
      ST_CMP: begin
        if (cmp_ack) begin
          if (cmp_a_gt_b) begin
            shift_en = 1'b1;
            if (pos == IDX_W'(1)) begin
              wr_en = 1'b1;
              if (last_entry) begin
                st_nxt = ST_FIN;
              end else begin
                cur_nxt = cur + IDX_W'(1);
                pos_nxt = cur + IDX_W'(1);
              end
            end else begin
              pos_nxt = pos - IDX_W'(1);
            end
          end else begin
            wr_en = 1'b1;
            if (last_entry) begin
              st_nxt = ST_FIN;
            end else begin
              cur_nxt = cur + IDX_W'(1);
              pos_nxt = cur + IDX_W'(1);
            end
          end
        end
      end
      ST_FIN:  st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign ptr_en = n_ld || (st == ST_CMP && cmp_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st <= ST_IDLE;
    else
      st <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      pos <= '0;
    end else if (ptr_en) begin
      cur <= cur_nxt;
      pos <= pos_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      n_q <= '0;
    else if (n_ld)
      n_q <= n_nxt;
  end

  assign cmp_req    = (st == ST_CMP);
  assign cmp_b      = cur;
  assign probe_slot = pos - IDX_W'(1);
  assign shift_dst  = pos;
  assign wr_slot    = cmp_a_gt_b ? '0 : pos;
  assign wr_val     = cur;
  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_FIN);
  assign n_eff      = n_q;

  // Comparison budget counter, used only by the check below
  logic [PW-1:0] cmp_used;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmp_used <= '0;
    else if (n_ld)
      cmp_used <= '0;
    else if (st == ST_CMP && cmp_ack)
      cmp_used <= cmp_used + PW'(1);
  end

  assert_cmp_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMP) |-> ((cmp_used << 1) <= PW'(n_q) * (PW'(n_q) - PW'(1))));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_probe_below_cur_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> (pos != '0 && pos <= cur));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_q));
endmodule

// File: rtl/rs_trim.sv
module rs_trim #(
  parameter int MAX_N    = 16,
  parameter int MAX_TRIM = 4,
  localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] trim_count,
  input  logic [CNT_W-1:0] n_eff,
  input  logic [IDX_W-1:0] rd_rank,
  output logic             rd_keep
);
  logic [CNT_W-1:0] q_q, q_clip;
  logic [CNT_W:0]   rank_ext, upper_sum;

  assign q_clip = (trim_count > CNT_W'(MAX_TRIM)) ? CNT_W'(MAX_TRIM) : trim_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_q <= '0;
    else if (load)
      q_q <= q_clip;
  end

  assign rank_ext  = (CNT_W+1)'(rd_rank);
  assign upper_sum = rank_ext + (CNT_W+1)'(q_q);
  assign rd_keep   = (rank_ext >= (CNT_W+1)'(q_q)) && (upper_sum < (CNT_W+1)'(n_eff));

  assert_trim_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_q <= CNT_W'(MAX_TRIM));
endmodule

// File: rtl/rank_sorter.sv
module rank_sorter #(
  parameter int MAX_N    = 16,
  parameter int MAX_TRIM = 4,
  localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] num_entries,
  input  logic [CNT_W-1:0] trim_count,
  output logic             cmp_req,
  output logic [IDX_W-1:0] cmp_idx_a,
  output logic [IDX_W-1:0] cmp_idx_b,
  input  logic             cmp_ack,
  input  logic             cmp_a_gt_b,
  output logic             busy,
  output logic             done,
  input  logic [IDX_W-1:0] rd_rank,
  output logic [IDX_W-1:0] rd_index,
  output logic             rd_keep
);
  logic             init_en, shift_en, wr_en;
  logic [IDX_W-1:0] shift_dst, wr_slot, wr_val, probe_slot;
  logic [CNT_W-1:0] n_eff;

  rs_seq #(.MAX_N(MAX_N)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .num_entries(num_entries),
    .cmp_ack    (cmp_ack),
    .cmp_a_gt_b (cmp_a_gt_b),
    .cmp_req    (cmp_req),
    .cmp_b      (cmp_idx_b),
    .probe_slot (probe_slot),
    .init_en    (init_en),
    .shift_en   (shift_en),
    .shift_dst  (shift_dst),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .wr_val     (wr_val),
    .busy       (busy),
    .done       (done),
    .n_eff      (n_eff)
  );

  rs_rank_table #(.MAX_N(MAX_N)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_en  (init_en),
    .shift_en (shift_en),
    .shift_dst(shift_dst),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_val   (wr_val),
    .rd_a_slot(probe_slot),
    .rd_a_val (cmp_idx_a),
    .rd_u_slot(rd_rank),
    .rd_u_val (rd_index)
  );

  rs_trim #(.MAX_N(MAX_N), .MAX_TRIM(MAX_TRIM)) u_trim (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start && !busy),
    .trim_count(trim_count),
    .n_eff     (n_eff),
    .rd_rank   (rd_rank),
    .rd_keep   (rd_keep)
  );

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && !cmp_ack) |=> (cmp_req && $stable(cmp_idx_a) && $stable(cmp_idx_b)));

  assert_pair_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> (cmp_idx_a != cmp_idx_b &&
                 CNT_W'(cmp_idx_a) < n_eff && CNT_W'(cmp_idx_b) < n_eff));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmp_req && !done));
endmodule

// File: tb/rank_sorter_bench.sv
`timescale 1ns/1ps
module rank_sorter_bench;
  localparam int MAX_N    = 16;
  localparam int MAX_TRIM = 4;
  localparam int IDX_W    = 4;
  localparam int CNT_W    = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [CNT_W-1:0] num_entries, trim_count;
  logic             cmp_req, cmp_ack, cmp_a_gt_b;
  logic [IDX_W-1:0] cmp_idx_a, cmp_idx_b;
  logic             busy, done;
  logic [IDX_W-1:0] rd_rank, rd_index;
  logic             rd_keep;

  int vals [MAX_N];
  int exp_at [MAX_N];
  int n_checks = 0;
  int n_fails  = 0;
  int ncmp     = 0;
  int lat      = 0;

  always #2.5 clk = ~clk;

  rank_sorter #(.MAX_N(MAX_N), .MAX_TRIM(MAX_TRIM)) u_rank_sorter (
    .clk(clk), .rst_n(rst_n), .start(start), .num_entries(num_entries),
    .trim_count(trim_count), .cmp_req(cmp_req), .cmp_idx_a(cmp_idx_a),
    .cmp_idx_b(cmp_idx_b), .cmp_ack(cmp_ack), .cmp_a_gt_b(cmp_a_gt_b),
    .busy(busy), .done(done), .rd_rank(rd_rank), .rd_index(rd_index),
    .rd_keep(rd_keep)
  );

  // Ideal comparator with random answer delay of 0 to 3 cycles
  initial begin
    cmp_ack    = 1'b0;
    cmp_a_gt_b = 1'b0;
    forever begin
      @(negedge clk);
      cmp_ack = 1'b0;
      if (cmp_req) begin
        if (lat == 0) begin
          cmp_ack    = 1'b1;
          cmp_a_gt_b = vals[cmp_idx_a] > vals[cmp_idx_b];
          ncmp++;
          lat = int'($urandom % 4);
        end else begin
          lat--;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int n, input int q, input int pat, input bit inject);
    int neff, qeff, rk, cyc;
    neff = (n > MAX_N) ? MAX_N : n;
    qeff = (q > MAX_TRIM) ? MAX_TRIM : q;
    for (int i = 0; i < MAX_N; i++) begin
      case (pat)
        0: vals[i] = int'($urandom % 8);
        1: vals[i] = i * 3;
        2: vals[i] = 100 - i;
        3: vals[i] = 7;
        default: vals[i] = int'($urandom % 1000);
      endcase
    end
    // expected entry at each rank: ties broken by lower index first
    for (int i = 0; i < neff; i++) begin
      rk = 0;
      for (int j = 0; j < neff; j++)
        if (vals[j] < vals[i] || (vals[j] == vals[i] && j < i)) rk++;
      exp_at[rk] = i;
    end
    ncmp = 0;
    @(negedge clk);
    start = 1'b1; num_entries = CNT_W'(n); trim_count = CNT_W'(q);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    if (inject && neff >= 2) begin
      while (!cmp_req && cyc < 100) begin @(negedge clk); cyc++; end
      start = 1'b1; num_entries = CNT_W'(2); trim_count = CNT_W'(0);
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(done, "R6 done reached", int'(done), 1);
    if (neff <= 1) chk(ncmp == 0, "R6 no comparison for n<=1", ncmp, 0);
    chk(ncmp <= neff * (neff - 1) / 2, "R5 comparison budget", ncmp, neff * (neff - 1) / 2);
    for (int r = 0; r < neff; r++) begin
      rd_rank = IDX_W'(r);
      #1;
      chk(int'(rd_index) == exp_at[r], (pat == 3) ? "R3 tie order" :
          (n > MAX_N) ? "R10 clipped count order" : inject ? "R9 busy start ignored" :
          "R2 ascending order", int'(rd_index), exp_at[r]);
      chk(rd_keep == (r >= qeff && r < neff - qeff), (q > MAX_TRIM) ? "R8 trim clip" :
          "R7 keep flag", int'(rd_keep), int'(r >= qeff && r < neff - qeff));
    end
    if (neff < MAX_N) begin
      rd_rank = IDX_W'(neff);
      #1;
      chk(rd_keep == 1'b0, "R7 keep beyond n", int'(rd_keep), 0);
    end
    @(negedge clk);
    chk(!done, "R6 done single cycle", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; num_entries = '0; trim_count = '0; rd_rank = '0;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !cmp_req, "R1 reset state", int'({done, busy, cmp_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !cmp_req, "R1 after reset", int'({done, busy, cmp_req}), 0);
    for (int p = 0; p < 5; p++)
      for (int n = 0; n <= MAX_N + 1; n++)
        run_case(n, (n + p) % 6, p, (p == 4) && (n % 3 == 0));
    run_case(20, 2, 0, 1'b0);
    run_case(20, 9, 2, 1'b0);
    run_case(MAX_N, MAX_N, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R6 watchdog: actual no completion, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule